// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Line-Error Flags

This block takes an asynchronous serial line and turns each frame (a low start bit, 8 data bits sent least significant bit first, an optional ninth data bit, and a high stop bit) into a character in a one-entry receive buffer. The line is sampled on a 16x oversampling tick that is generated outside the block. Once a character is stored, a ready flag is raised. Alongside the character path, the block watches for three line problems: a stop bit that is not high, a line held low for far longer than any frame lasts, and a character that arrives before the previous one was read. Each problem sets a flag of its own.

Software clears the ready flag and the error flags through a write-one-to-clear strobe with a four-bit mask. The block produces an interrupt request from the ready flag and a separate status request from the error flags, and the status request can be gated off. It also routes a transmit request from elsewhere. In combined mode, receive and transmit share a single output. In split mode, transmit has an output of its own, and the status request stays on the receive output.

The receive sequencer has four states. RX_IDLE waits for a low sample on a tick and then goes to RX_START. RX_START votes on the start bit at mid-period: if the vote is high it returns to RX_IDLE, otherwise it moves to RX_DATA at the end of the period. RX_DATA stores one voted bit per period and goes to RX_STOP after the last data bit. RX_STOP votes on the stop bit at mid-period, reports the completed frame and returns to RX_IDLE.

Top module: `serial_rx_errs`

## Requirements
- R1: The line passes through a two-flop synchronizer. Each bit is the majority of samples 7, 8 and 9 of its 16-tick period. A start bit whose vote is high returns the receiver to idle, and no character is stored.
- R2: With ninth-bit mode off, an 8-bit frame is stored LSB first in rx_data[7:0]. rx_data[8] reads 0, and rx_ready sets.
- R3: With ninth-bit mode on, the bit that follows the 8 data bits is stored in rx_data[8].
- R4: err_frame sets when the stop-bit vote is low. The character is still stored if the buffer is free.
- R5: err_break sets once the synchronized line has been low for 11 consecutive bit periods (176 ticks), regardless of frame boundaries. A low run of 10 bit periods does not set it.
- R6: If a frame completes while rx_ready is set, err_overrun sets, the new character is discarded and rx_data keeps the unread character.
- R7: The flags stay set until cleared. A cycle with clr_we high clears the flags selected by clr_mask: bit 0 clears rx_ready, bit 1 err_overrun, bit 2 err_break, bit 3 err_frame. Unselected flags are unaffected. A set in the same cycle wins over a clear.
- R8: With stat_int_en at 1, any error flag raises irq_main. With stat_int_en at 0, the error flags have no effect on any interrupt output.
- R9: rx_ready raises irq_main whatever the value of stat_int_en.
- R10: With split_irq at 0, tx_irq_in is ORed onto irq_main and irq_aux stays 0. With split_irq at 1, tx_irq_in drives only irq_aux, and the status request remains on irq_main.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| ninth_en | input | 1 | Receive a ninth data bit |
| stat_int_en | input | 1 | Let error flags raise the status request |
| split_irq | input | 1 | 1: separate receive/transmit outputs; 0: combined |
| tx_irq_in | input | 1 | Transmit interrupt request from the transmitter |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 4 | Flags to clear (0 ready, 1 overrun, 2 break, 3 frame) |
| rx_data | output | 9 | Receive buffer |
| rx_ready | output | 1 | Receive buffer holds an unread character |
| err_frame | output | 1 | Sticky framing error |
| err_break | output | 1 | Sticky break detect |
| err_overrun | output | 1 | Sticky overrun |
| irq_main | output | 1 | Receive (and combined) interrupt request |
| irq_aux | output | 1 | Separate transmit interrupt request |

## Verification
The receive path is driven with several frames. Alternating-bit bytes in 8-bit and 9-bit mode tell apart a correct bit order from a reversed or shifted one. A frame with a low stop bit separates a framing error from a break. Runs of all-zero bits lasting 10 and 12 bit periods bracket the 11-period break threshold, and back-to-back frames without a clear show whether the second character is discarded. A short low glitch shows whether the start-bit vote is used. Each combination of the interrupt controls is then checked against the expected routing of the ready, status and transmit requests.

// File: rtl/rx_pkg.sv
package rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/rx_sync2.sv
module rx_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/rx_break_det.sv
module rx_break_det #(
    parameter int OVS        = 16,
    parameter int BREAK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    output logic brk_hit
);
    localparam int LIM = OVS * BREAK_BITS;
    localparam int CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] LIM_V  = CW'(LIM);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIM - 1);

    logic [CW-1:0] low_cnt;

    // Counts ticks of an unbroken low run and saturates at the limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (line) begin
            low_cnt <= '0;
        end else if (tick && (low_cnt != LIM_V)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign brk_hit = tick && !line && (low_cnt == LIM_M1);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int DATA_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               line,
    input  logic               ninth_en,
    output logic               done,
    output logic               frame_bad,
    output logic [DATA_BITS:0] word
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DATA_BITS + 1);
    localparam logic [CW-1:0] SMP_A = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] SMP_B = CW'(OVS / 2);
    localparam logic [CW-1:0] SMP_C = CW'(OVS / 2 + 1);
    localparam logic [CW-1:0] LAST  = CW'(OVS - 1);

    rx_state_t       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [IW-1:0]   idx_q;
    logic [IW-1:0]   idx_last;
    logic            s_a_q, s_b_q;
    logic            vote, mid, last;
    logic [DATA_BITS:0] word_q;

    assign vote     = (s_a_q & s_b_q) | (s_a_q & line) | (s_b_q & line);
    assign mid      = tick && (cnt_q == SMP_C);
    assign last     = tick && (cnt_q == LAST);
    assign idx_last = ninth_en ? IW'(DATA_BITS) : IW'(DATA_BITS - 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (tick && !line)                 state_d = RX_START;
            RX_START: if (mid && vote)                   state_d = RX_IDLE;
                      else if (last)                     state_d = RX_DATA;
            RX_DATA:  if (last && (idx_q == idx_last))   state_d = RX_STOP;
            RX_STOP:  if (mid)                           state_d = RX_IDLE;
            default:                                     state_d = RX_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            s_a_q     <= 1'b1;
            s_b_q     <= 1'b1;
            word_q    <= '0;
            done      <= 1'b0;
            frame_bad <= 1'b0;
        end else begin
            done      <= 1'b0;
            frame_bad <= 1'b0;
            if (state_q == RX_IDLE) begin
                cnt_q <= (tick && !line) ? CW'(1) : '0;
            end else if (tick) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
            if (tick && (cnt_q == SMP_A)) s_a_q <= line;
            if (tick && (cnt_q == SMP_B)) s_b_q <= line;
            unique case (state_q)
                RX_IDLE:  ;
                RX_START: begin
                    if (mid)  word_q <= '0;
                    if (last) idx_q  <= '0;
                end
                RX_DATA: begin
                    if (mid)  word_q[idx_q] <= vote;
                    if (last) idx_q <= idx_q + 1'b1;
                end
                RX_STOP: begin
                    if (mid) begin
                        done      <= 1'b1;
                        frame_bad <= !vote;
                    end
                end
                default: ;
            endcase
        end
    end

    assign word = word_q;
endmodule

// File: rtl/serial_rx_errs.sv
module serial_rx_errs #(
    parameter int OVS        = 16,
    parameter int DATA_BITS  = 8,
    parameter int BREAK_BITS = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               rx_in,
    input  logic               ninth_en,
    input  logic               stat_int_en,
    input  logic               split_irq,
    input  logic               tx_irq_in,
    input  logic               clr_we,
    input  logic [3:0]         clr_mask,
    output logic [DATA_BITS:0] rx_data,
    output logic               rx_ready,
    output logic               err_frame,
    output logic               err_break,
    output logic               err_overrun,
    output logic               irq_main,
    output logic               irq_aux
);
    logic               line;
    logic               brk_hit;
    logic               done;
    logic               frame_bad;
    logic [DATA_BITS:0] word;
    logic               clr_rdy, clr_ovr, clr_brk, clr_frm;
    logic               stat_req;

    rx_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(rx_in), .q_sync(line)
    );

    rx_break_det #(.OVS(OVS), .BREAK_BITS(BREAK_BITS)) u_brk (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(line), .brk_hit(brk_hit)
    );

    rx_frame_fsm #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(line),
        .ninth_en(ninth_en), .done(done), .frame_bad(frame_bad), .word(word)
    );

    assign clr_rdy = clr_we & clr_mask[0];
    assign clr_ovr = clr_we & clr_mask[1];
    assign clr_brk = clr_we & clr_mask[2];
    assign clr_frm = clr_we & clr_mask[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            err_frame   <= 1'b0;
            err_break   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            rx_ready    <= (rx_ready & ~clr_rdy) | (done & ~rx_ready);
            err_overrun <= (err_overrun & ~clr_ovr) | (done & rx_ready);
            err_frame   <= (err_frame & ~clr_frm) | (done & frame_bad);
            err_break   <= (err_break & ~clr_brk) | brk_hit;
            if (done && !rx_ready) rx_data <= word;
        end
    end

    assign stat_req = stat_int_en & (err_frame | err_break | err_overrun);
    assign irq_main = rx_ready | stat_req | (~split_irq & tx_irq_in);
    assign irq_aux  = split_irq & tx_irq_in;
endmodule

// File: rtl/serial_rx_errs_chk.sv
module serial_rx_errs_chk #(
    parameter int DATA_BITS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stat_int_en,
    input logic               split_irq,
    input logic               tx_irq_in,
    input logic               clr_we,
    input logic [3:0]         clr_mask,
    input logic [DATA_BITS:0] rx_data,
    input logic               rx_ready,
    input logic               err_frame,
    input logic               err_overrun,
    input logic               irq_main,
    input logic               irq_aux
);
    assert_frame_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame && !(clr_we && clr_mask[3]) |=> err_frame);

    assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(rx_ready));

    assert_keep_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && !(clr_we && clr_mask[0]) |=> rx_ready && $stable(rx_data));

    assert_stat_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_int_en && !rx_ready && !split_irq && !tx_irq_in |-> !irq_main);

    assert_ready_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> irq_main);

    assert_aux_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !split_irq |-> !irq_aux);

    assert_aux_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        split_irq && tx_irq_in |-> irq_aux);
endmodule

bind serial_rx_errs serial_rx_errs_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .stat_int_en(stat_int_en), .split_irq(split_irq),
    .tx_irq_in(tx_irq_in), .clr_we(clr_we), .clr_mask(clr_mask),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_frame(err_frame),
    .err_overrun(err_overrun), .irq_main(irq_main), .irq_aux(irq_aux)
);

// File: tb/serial_rx_errs_tb.sv
module serial_rx_errs_tb;
    localparam int BIT_CLKS = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       ninth_en = 1'b0;
    logic       stat_int_en = 1'b0;
    logic       split_irq = 1'b0;
    logic       tx_irq_in = 1'b0;
    logic       clr_we = 1'b0;
    logic [3:0] clr_mask = 4'h0;
    logic [8:0] rx_data;
    logic       rx_ready, err_frame, err_break, err_overrun, irq_main, irq_aux;

    int n_run = 0;
    int n_fail = 0;
    int tick_div = 0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tick_div  <= (tick_div == 3) ? 0 : tick_div + 1;
        baud_tick <= (tick_div == 3);
    end

    serial_rx_errs u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
        .ninth_en(ninth_en), .stat_int_en(stat_int_en), .split_irq(split_irq),
        .tx_irq_in(tx_irq_in), .clr_we(clr_we), .clr_mask(clr_mask),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_frame(err_frame),
        .err_break(err_break), .err_overrun(err_overrun),
        .irq_main(irq_main), .irq_aux(irq_aux)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bits(input logic v, input int nbits);
        rx_in = v;
        repeat (nbits * BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input logic nine, input logic stop);
        hold_bits(1'b0, 1);
        for (int i = 0; i < 8; i++) hold_bits(d[i], 1);
        if (nine) hold_bits(d[8], 1);
        hold_bits(stop, 1);
        hold_bits(1'b1, 1);
    endtask

    task automatic clear(input logic [3:0] m);
        @(negedge clk);
        clr_we = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = 4'h0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R7 reset ready", 32'(rx_ready), 0);
        check("R7 reset flags", {29'd0, err_frame, err_break, err_overrun}, 0);
        check("R10 reset irqs", {30'd0, irq_main, irq_aux}, 0);
    endtask

    task automatic t_plain;
        send_frame(9'h0A5, 1'b0, 1'b1);
        check("R2 data A5", 32'(rx_data), 32'h0A5);
        check("R2 ready", 32'(rx_ready), 1);
        check("R4 no frame err", 32'(err_frame), 0);
        clear(4'h1);
        check("R7 ready cleared", 32'(rx_ready), 0);
        send_frame(9'h03C, 1'b0, 1'b1);
        check("R2 data 3C", 32'(rx_data), 32'h03C);
        clear(4'hF);
    endtask

    task automatic t_ninth;
        ninth_en = 1'b1;
        send_frame(9'h15A, 1'b1, 1'b1);
        check("R3 ninth bit data", 32'(rx_data), 32'h15A);
        clear(4'hF);
        ninth_en = 1'b0;
    endtask

    task automatic t_frame_irq;
        send_frame(9'h081, 1'b0, 1'b0);
        hold_bits(1'b1, 2);
        check("R4 frame err set", 32'(err_frame), 1);
        check("R4 char stored", 32'(rx_data), 32'h081);
        clear(4'h1);
        check("R7 frame kept after ready clear", 32'(err_frame), 1);
        stat_int_en = 1'b0;
        @(negedge clk);
        check("R8 gated off", 32'(irq_main), 0);
        stat_int_en = 1'b1;
        @(negedge clk);
        check("R8 status irq", 32'(irq_main), 1);
        split_irq = 1'b1; tx_irq_in = 1'b1;
        @(negedge clk);
        check("R10 status on rx output", {30'd0, irq_main, irq_aux}, 32'h3);
        split_irq = 1'b0; tx_irq_in = 1'b0; stat_int_en = 1'b0;
        clear(4'hF);
        check("R7 frame cleared", 32'(err_frame), 0);
    endtask

    task automatic t_overrun;
        send_frame(9'h011, 1'b0, 1'b1);
        send_frame(9'h022, 1'b0, 1'b1);
        check("R6 overrun set", 32'(err_overrun), 1);
        check("R6 old char kept", 32'(rx_data), 32'h011);
        clear(4'h2);
        check("R7 overrun cleared", 32'(err_overrun), 0);
        check("R7 ready untouched", 32'(rx_ready), 1);
        clear(4'hF);
    endtask

    task automatic t_break;
        send_frame(9'h000, 1'b0, 1'b0);   // 10 low bit periods
        hold_bits(1'b1, 2);
        check("R5 10 periods no break", 32'(err_break), 0);
        check("R4 frame err on zero frame", 32'(err_frame), 1);
        clear(4'hF);
        hold_bits(1'b0, 12);
        hold_bits(1'b1, 24);
        check("R5 break set", 32'(err_break), 1);
        clear(4'hF);
        check("R5 break cleared", 32'(err_break), 0);
    endtask

    task automatic t_glitch;
        rx_in = 1'b0;
        repeat (8) @(negedge clk);
        hold_bits(1'b1, 12);
        check("R1 glitch rejected", 32'(rx_ready), 0);
    endtask

    task automatic t_route;
        split_irq = 1'b0; tx_irq_in = 1'b1;
        @(negedge clk);
        check("R10 combined", {30'd0, irq_main, irq_aux}, 32'h2);
        split_irq = 1'b1;
        @(negedge clk);
        check("R10 split", {30'd0, irq_main, irq_aux}, 32'h1);
        tx_irq_in = 1'b0;
        send_frame(9'h066, 1'b0, 1'b1);
        check("R9 ready irq", 32'(irq_main), 1);
        split_irq = 1'b0;
        clear(4'hF);
        check("R9 irq drops", 32'(irq_main), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_plain();
        t_ninth();
        t_frame_irq();
        t_overrun();
        t_break();
        t_glitch();
        t_route();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule